// File: doc/BRIEF.md
# Expanding Bidirectional Barrel Shifter

This block shifts a 64-bit word left or right by any amount from 0 to 63 and returns the whole double-width result as two separate 64-bit words. Nothing is ORed or dropped: every bit of the source word appears in exactly one of the two outputs. One word holds the part that stays in the source's own position (the primary word) and the other holds the part pushed past the word edge. This makes the block a natural helper for splitting a register into the two pieces needed by a store that crosses a word boundary.

The datapath holds a left-shifting unit and a right-shifting unit. Each is a chain of binary-weighted stages: six stages of 2:1 muxes by default, or three stages of 4:1 muxes when the radix-4 build is chosen. A recombination mux picks the result of one unit and orders its two halves by direction. A byte-offset mode takes the shift amount from the low three bits of a byte address, scaled by eight. An optional pipeline register placed between the middle stages adds one cycle of latency and carries the valid flag with the data.

Top module: `exp_shifter`

## Requirements
- R1: With `dir_right`=0 the block forms the 128-bit value {64 zeros, data} shifted left by n; `word_lo` is bits 63:0 of that value and `word_hi` is bits 127:64.
- R2: With `dir_right`=1 the block forms the 128-bit value {data, 64 zeros} shifted right by n; `word_lo` is bits 127:64 of that value and `word_hi` is bits 63:0.
- R3: Every shift amount from 0 to 63 is supported in both directions, including the extreme amount 63.
- R4: The two output words are never combined: the number of set bits in `word_lo` plus that in `word_hi` equals the number of set bits in the data.
- R5: With `byte_mode`=0 only bits 5:0 of `shift_amt` set n; bits 7:6 have no effect on the outputs.
- R6: With n=0 the data appears unchanged on `word_lo` and `word_hi` is all zeros, in either direction.
- R7: With `byte_mode`=1, n equals `shift_amt` bits 2:0 times 8; bits 7:3 of `shift_amt` have no effect.
- R8: With PIPE=0 the outputs and `valid_out` follow the inputs in the same cycle; with PIPE=1 they appear exactly one clock edge after the inputs are presented, and `valid_out` follows `valid_in` with the same delay.
- R9: The radix-4 build (RADIX4=1) gives the same outputs as the radix-2 build for every input.
- R10: With PIPE=1, `valid_out` is 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Input word is valid |
| data_in | input | 64 | Word to shift |
| shift_amt | input | 8 | Shift amount or byte address low bits |
| dir_right | input | 1 | 0 shifts left, 1 shifts right |
| byte_mode | input | 1 | 1 takes the amount as a byte offset (bits 2:0 times 8) |
| valid_out | output | 1 | Output words are valid |
| word_lo | output | 64 | Primary output word |
| word_hi | output | 64 | Spill-over output word |

## Verification
The bench aims at the shift amounts where the word edge matters: zero, one, 32, 33 and 63, in both directions, where a swapped recombination or a lost stage puts bits in the wrong word or drops them. Amounts with bits set above bit 5, and byte-mode addresses with high bits set, catch a design that lets those bits reach the stages or forgets the scaling by eight. A radix-4 instance runs next to the radix-2 one with no pipeline, so a stage weighted by the wrong step shows as a mismatch, and the pipelined instance is sampled on the exact edge so an extra or missing register shows up as stale data or a late valid flag.

// File: rtl/exp_shift_pkg.sv
package exp_shift_pkg;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shift_dir_e;

  // select bits consumed by one stage
  function automatic int unsigned sel_bits(input bit radix4);
    return radix4 ? 2 : 1;
  endfunction

  // number of stages needed to cover log_w amount bits
  function automatic int unsigned stage_count(input int unsigned log_w,
                                              input int unsigned rb);
    return (log_w + rb - 1) / rb;
  endfunction

endpackage

// File: rtl/exp_shift_stage.sv
module exp_shift_stage #(
  parameter int unsigned VW   = 128,
  parameter int unsigned RB   = 1,
  parameter int unsigned STEP = 1,
  parameter bit          LEFT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] din,
  input  logic [RB-1:0] sel,
  output logic [VW-1:0] dout
);

  localparam int unsigned NWAY = 1 << RB;

  always_comb begin
    dout = din;
    for (int j = 1; j < NWAY; j++) begin
      if (sel == RB'(j)) begin
        dout = LEFT ? (din << (j * STEP)) : (din >> (j * STEP));
      end
    end
  end

  // R4
  bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dout) == $countones(din));

endmodule

// File: rtl/exp_shift_unit.sv
module exp_shift_unit #(
  parameter int unsigned W      = 64,
  parameter int unsigned LOG_W  = 6,
  parameter bit          RADIX4 = 1'b0,
  parameter bit          LEFT   = 1'b1,
  parameter bit          PIPE   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2*W-1:0]   din,
  input  logic [LOG_W-1:0] amt,
  output logic [2*W-1:0]   dout
);
  import exp_shift_pkg::*;

  localparam int unsigned RB      = sel_bits(RADIX4);
  localparam int unsigned NST     = stage_count(LOG_W, RB);
  localparam int unsigned PAD     = NST * RB;
  localparam int unsigned PIPE_AT = NST / 2;

  logic [PAD-1:0] amt_pad;
  logic [PAD-1:0] amt_late;
  logic [2*W-1:0] v [0:NST];

  assign amt_pad = PAD'(amt);
  assign v[0]    = din;

  if (PIPE) begin : g_pipe
    logic [2*W-1:0] mid_q;
    logic [PAD-1:0] amt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mid_q <= '0;
        amt_q <= '0;
      end else begin
        mid_q <= v[PIPE_AT];
        amt_q <= amt_pad;
      end
    end
    assign amt_late = amt_q;
    for (genvar k = 0; k < NST; k++) begin : g_st
      logic [2*W-1:0] st_in;
      logic [RB-1:0]  st_sel;
      if (k == PIPE_AT) begin : g_cut
        assign st_in = mid_q;
      end else begin : g_thru
        assign st_in = v[k];
      end
      if (k >= PIPE_AT) begin : g_late
        assign st_sel = amt_late[k*RB +: RB];
      end else begin : g_early
        assign st_sel = amt_pad[k*RB +: RB];
      end
      exp_shift_stage #(.VW(2*W), .RB(RB), .STEP(1 << (k*RB)), .LEFT(LEFT)) u_stage (
        .clk(clk), .rst_n(rst_n), .din(st_in), .sel(st_sel), .dout(v[k+1]));
    end
  end else begin : g_flat
    assign amt_late = amt_pad;
    for (genvar k = 0; k < NST; k++) begin : g_st
      exp_shift_stage #(.VW(2*W), .RB(RB), .STEP(1 << (k*RB)), .LEFT(LEFT)) u_stage (
        .clk(clk), .rst_n(rst_n), .din(v[k]), .sel(amt_late[k*RB +: RB]), .dout(v[k+1]));
    end
  end

  assign dout = v[NST];

endmodule

// File: rtl/exp_shift_recombine.sv
module exp_shift_recombine #(
  parameter int unsigned W = 64
) (
  input  logic [2*W-1:0] left_res,
  input  logic [2*W-1:0] right_res,
  input  logic           dir_right,
  output logic [W-1:0]   word_lo,
  output logic [W-1:0]   word_hi
);
  import exp_shift_pkg::*;

  shift_dir_e dir;
  assign dir = shift_dir_e'(dir_right);

  always_comb begin
    if (dir == DIR_RIGHT) begin
      word_lo = right_res[2*W-1:W];
      word_hi = right_res[W-1:0];
    end else begin
      word_lo = left_res[W-1:0];
      word_hi = left_res[2*W-1:W];
    end
  end

endmodule

// File: rtl/exp_shifter.sv
module exp_shifter #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned AMT_W  = 8,
  parameter bit          RADIX4 = 1'b0,
  parameter bit          PIPE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [AMT_W-1:0]  shift_amt,
  input  logic              dir_right,
  input  logic              byte_mode,
  output logic              valid_out,
  output logic [DATA_W-1:0] word_lo,
  output logic [DATA_W-1:0] word_hi
);

  localparam int unsigned LOG_W = $clog2(DATA_W);

  // effective bit shift: low log2 bits, or byte offset times eight
  function automatic logic [LOG_W-1:0] eff_shift(input logic [AMT_W-1:0] a,
                                                 input logic bm);
    logic [LOG_W-1:0] n;
    if (bm) n = LOG_W'(a[2:0]) << 3;
    else    n = a[LOG_W-1:0];
    return n;
  endfunction

  logic [LOG_W-1:0]    eff_amt;
  logic [LOG_W-1:0]    eff_out;
  logic                dir_out;
  logic [2*DATA_W-1:0] left_res;
  logic [2*DATA_W-1:0] right_res;

  assign eff_amt = eff_shift(shift_amt, byte_mode);

  exp_shift_unit #(.W(DATA_W), .LOG_W(LOG_W), .RADIX4(RADIX4), .LEFT(1'b1), .PIPE(PIPE)) u_left (
    .clk(clk), .rst_n(rst_n),
    .din({{DATA_W{1'b0}}, data_in}), .amt(eff_amt), .dout(left_res));

  exp_shift_unit #(.W(DATA_W), .LOG_W(LOG_W), .RADIX4(RADIX4), .LEFT(1'b0), .PIPE(PIPE)) u_right (
    .clk(clk), .rst_n(rst_n),
    .din({data_in, {DATA_W{1'b0}}}), .amt(eff_amt), .dout(right_res));

  if (PIPE) begin : g_ctl_q
    logic valid_q, dir_q;
    logic [LOG_W-1:0] eff_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        dir_q   <= 1'b0;
        eff_q   <= '0;
      end else begin
        valid_q <= valid_in;
        dir_q   <= dir_right;
        eff_q   <= eff_amt;
      end
    end
    assign valid_out = valid_q;
    assign dir_out   = dir_q;
    assign eff_out   = eff_q;

    // R8
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);
  end else begin : g_ctl_c
    assign valid_out = valid_in;
    assign dir_out   = dir_right;
    assign eff_out   = eff_amt;
  end

  exp_shift_recombine #(.W(DATA_W)) u_recombine (
    .left_res(left_res), .right_res(right_res), .dir_right(dir_out),
    .word_lo(word_lo), .word_hi(word_hi));

  // R6
  zero_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_out == '0) |-> (word_hi == '0));

  // R7
  byte_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> (eff_amt[2:0] == 3'b000));

endmodule

// File: tb/exp_shifter_tb_top.sv
module exp_shifter_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_in = 1'b0;
  logic [63:0] data_in = '0;
  logic [7:0]  shift_amt = '0;
  logic dir_right = 1'b0;
  logic byte_mode = 1'b0;

  logic        v_p, v_r;
  logic [63:0] lo_p, hi_p, lo_r, hi_r;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  // pipelined radix-2 build
  exp_shifter #(.RADIX4(1'b0), .PIPE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .data_in(data_in),
    .shift_amt(shift_amt), .dir_right(dir_right), .byte_mode(byte_mode),
    .valid_out(v_p), .word_lo(lo_p), .word_hi(hi_p));

  // unpipelined radix-4 build
  exp_shifter #(.RADIX4(1'b1), .PIPE(1'b0)) dut_r4 (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .data_in(data_in),
    .shift_amt(shift_amt), .dir_right(dir_right), .byte_mode(byte_mode),
    .valid_out(v_r), .word_lo(lo_r), .word_hi(hi_r));

  // bit-by-bit placement model, returns {hi, lo}
  function automatic logic [127:0] model(input logic [63:0] d, input logic [7:0] a,
                                         input logic right, input logic bm);
    int n;
    logic [63:0] lo, hi;
    n  = bm ? (int'(a % 8) * 8) : int'(a % 64);
    lo = '0;
    hi = '0;
    for (int i = 0; i < 64; i++) begin
      if (!right) begin
        if (i + n < 64) lo[i+n] = d[i];
        else            hi[i+n-64] = d[i];
      end else begin
        if (i - n >= 0) lo[i-n] = d[i];
        else            hi[64+i-n] = d[i];
      end
    end
    return {hi, lo};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  localparam int NV = 12;
  localparam logic [63:0] V_DATA [NV] = '{
    64'h0123456789ABCDEF, 64'h0123456789ABCDEF, 64'h8000000000000001,
    64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF,
    64'hDEADBEEFCAFEF00D, 64'hDEADBEEFCAFEF00D, 64'hDEADBEEFCAFEF00D,
    64'hA5A5A5A5A5A5A5A5, 64'h0000000000000001, 64'h8000000000000000};
  localparam logic [7:0] V_AMT [NV] = '{
    8'd0, 8'd0, 8'd1, 8'd63, 8'd63, 8'd12, 8'hC4, 8'h7F, 8'hFB, 8'd37, 8'd32, 8'd33};
  localparam logic V_DIR [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1,
                                  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic V_BM  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

  string v_req [NV];

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [127:0] e;
    v_req = '{"R6", "R6", "R1", "R3", "R3", "R2", "R5", "R7", "R7", "R4", "R1", "R2"};

    // R10: valid low while reset is held
    repeat (3) @(negedge clk);
    valid_in = 1'b1;
    #1;
    chk("R10", "valid_out in reset", {63'b0, v_p}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    valid_in = 1'b0;
    @(negedge clk);

    // vector table
    for (int k = 0; k < NV; k++) begin
      valid_in  = 1'b1;
      data_in   = V_DATA[k];
      shift_amt = V_AMT[k];
      dir_right = V_DIR[k];
      byte_mode = V_BM[k];
      e = model(V_DATA[k], V_AMT[k], V_DIR[k], V_BM[k]);
      #1;
      // R9: radix-4 unpipelined, same cycle
      chk("R9", $sformatf("r4 lo vec %0d", k), lo_r, e[63:0]);
      chk("R9", $sformatf("r4 hi vec %0d", k), hi_r, e[127:64]);
      @(posedge clk);
      @(negedge clk);
      chk(v_req[k], $sformatf("lo vec %0d", k), lo_p, e[63:0]);
      chk(v_req[k], $sformatf("hi vec %0d", k), hi_p, e[127:64]);
      if (k == 9) begin
        // R4: no bit lost or merged
        chk("R4", "set bit count", 64'($countones(lo_p) + $countones(hi_p)),
            64'($countones(V_DATA[k])));
      end
    end

    // R5: upper amount bits ignored, compare against plain amount
    data_in = 64'h00FF00FF00FF00FF; dir_right = 1'b1; byte_mode = 1'b0;
    shift_amt = 8'hC9;
    e = model(data_in, 8'd9, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R5", "lo amt C9 vs 9", lo_p, e[63:0]);
    chk("R5", "hi amt C9 vs 9", hi_p, e[127:64]);

    // R8: latency of data and valid on the pipelined build
    valid_in = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8", "valid_out low after idle", {63'b0, v_p}, 64'd0);
    valid_in = 1'b1;
    data_in = 64'h1; shift_amt = 8'd5; dir_right = 1'b0;
    #1;
    chk("R8", "pipe valid not yet", {63'b0, v_p}, 64'd0);
    chk("R8", "flat valid same cycle", {63'b0, v_r}, 64'd1);
    chk("R8", "flat data same cycle", lo_r, 64'h20);
    chk("R8", "pipe data not yet", lo_p, e[63:0]);
    @(posedge clk); @(negedge clk);
    chk("R8", "pipe valid after edge", {63'b0, v_p}, 64'd1);
    chk("R8", "pipe data after edge", lo_p, 64'h20);
    valid_in = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8", "pipe valid falls", {63'b0, v_p}, 64'd0);

    // R3/R2: right by one moves bit 0 into the spill word
    data_in = 64'h3; shift_amt = 8'd1; dir_right = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2", "right 1 lo", lo_p, 64'h1);
    chk("R2", "right 1 hi", hi_p, 64'h8000000000000000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule